// File: doc/BRIEF.md
# Preemptive Priority Channel Scheduler

This block picks which transmit channel is served next. In normal operation it visits the channels of a context table one at a time in round-robin order, moving on each time the transmit engine returns a service-complete strobe. The index of the channel in service is always present on its output.

The host can raise a priority demand. The scheduler does not cut off the channel in service. When that service completes, it runs once through a short priority list whose entries are context table indices. It serves every entry marked valid and skips the rest. When the list is used up, it lowers the demand flag, sends a one-cycle pass-complete pulse and goes back to round-robin order. It resumes at the table entry after the one that was in service when the demand was taken, so the round-robin position is kept rather than restarted.

The contents of the priority list arrive on plain input ports. The block does not fetch them from memory.

Top module: `prio_chan_sched`

## Requirements
- R1: While reset is high and in the cycle after it is released, serve_idx is 0, serve_pri is 0, demand_flag is 0 and pass_done is 0.
- R2: When svc_done is high at a clock edge in round-robin mode with demand_flag low, serve_idx becomes serve_idx+1 after that edge, and NUM_CH-1 wraps to 0.
- R3: A demand_set pulse raises demand_flag after the next edge. serve_idx and serve_pri do not change at any edge where svc_done is low, so the service in progress is never cut off.
- R4: At an svc_done edge in round-robin mode with demand_flag high and at least one valid priority entry, serve_pri becomes 1. serve_idx then takes the index held in the lowest-numbered valid entry.
- R5: Inside a priority pass, each svc_done edge moves to the next higher-numbered entry whose valid bit is set, and entries with a clear valid bit are skipped.
- R6: At the svc_done edge that ends the last valid entry of a pass, serve_idx takes the resume point and serve_pri returns to 0. The resume point is the entry after the one in service when the demand was taken, with wrap. At the same edge demand_flag clears and pass_done is high for exactly one cycle.
- R7: If no priority entry is valid when a demand is taken, the pass ends at once. serve_idx goes straight to the resume point, demand_flag clears and pass_done pulses.
- R8: A demand_set pulse while demand_flag is already high has no effect. The running pass is neither extended nor restarted, and the flag is clear after the pass ends.
- R9: Priority entry k holds its channel index in pri_idx_flat bits [k*IDX_W +: IDX_W], and its valid bit is pri_vld[k].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| svc_done | input | 1 | Service of the current channel has completed |
| demand_set | input | 1 | Host request for a priority pass |
| pri_idx_flat | input | PRI_DEPTH*IDX_W | Channel indices of the priority entries |
| pri_vld | input | PRI_DEPTH | Valid bit of each priority entry |
| serve_idx | output | IDX_W | Channel currently in service |
| serve_pri | output | 1 | High while serving a priority entry |
| demand_flag | output | 1 | Priority demand pending or in progress |
| pass_done | output | 1 | One-cycle pulse when a priority pass ends |

## Verification
Every result is registered and is due exactly one cycle after the stimulus. serve_idx, serve_pri, demand_flag and pass_done all change at the edge that samples svc_done high. demand_flag rises at the edge that samples demand_set. The driver pushes one expected tuple for each svc_done pulse it drives. The monitor notes at the clock edge whether svc_done was sampled, and it compares against the queue only at the falling edge that follows. Hold and pulse-width checks are taken at later falling edges with no service strobe pending.

// File: rtl/prisched_pkg.sv
package prisched_pkg;

    typedef enum logic {
        MODE_RR  = 1'b0,
        MODE_PRI = 1'b1
    } sched_mode_e;

    // Next round-robin position with wrap at n.
    function automatic int unsigned wrap_inc(int unsigned v, int unsigned n);
        return (v + 1 >= n) ? 0 : v + 1;
    endfunction

endpackage

// File: rtl/prisched_pick.sv
module prisched_pick #(
    parameter int DEPTH  = 4,
    parameter int SRCH_W = 3,
    parameter int POS_W  = 2
) (
    input  logic [DEPTH-1:0]  vld,
    input  logic [SRCH_W-1:0] start,
    output logic              found,
    output logic [POS_W-1:0]  pos
);
    // Lowest valid entry at or above start.
    always_comb begin
        found = 1'b0;
        pos   = '0;
        for (int k = DEPTH - 1; k >= 0; k--) begin
            if (vld[k] && (k >= int'(start))) begin
                found = 1'b1;
                pos   = POS_W'(k);
            end
        end
    end
endmodule

// File: rtl/prisched_demand_flag.sv
module prisched_demand_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_req,
    input  logic clr_req,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst)
            flag <= 1'b0;
        else if (clr_req)
            flag <= 1'b0;
        else if (set_req)
            flag <= 1'b1;
    end
endmodule

// File: rtl/prio_chan_sched.sv
module prio_chan_sched
    import prisched_pkg::*;
#(
    parameter int NUM_CH    = 8,
    parameter int PRI_DEPTH = 4,
    localparam int IDX_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       svc_done,
    input  logic                       demand_set,
    input  logic [PRI_DEPTH*IDX_W-1:0] pri_idx_flat,
    input  logic [PRI_DEPTH-1:0]       pri_vld,
    output logic [IDX_W-1:0]           serve_idx,
    output logic                       serve_pri,
    output logic                       demand_flag,
    output logic                       pass_done
);
    localparam int POS_W  = (PRI_DEPTH > 1) ? $clog2(PRI_DEPTH) : 1;
    localparam int SRCH_W = $clog2(PRI_DEPTH + 1);

    sched_mode_e      mode_q, mode_d;
    logic [IDX_W-1:0] cur_q, cur_d;
    logic [IDX_W-1:0] res_q, res_d;
    logic [POS_W-1:0] ptr_q, ptr_d;
    logic             pdone_q, pdone_d;
    logic             flag_clr;

    logic [SRCH_W-1:0] srch_start;
    logic              pick_found;
    logic [POS_W-1:0]  pick_pos;
    logic [IDX_W-1:0]  pick_idx;
    logic [IDX_W-1:0]  rr_next;

    assign srch_start = (mode_q == MODE_PRI) ? SRCH_W'(ptr_q) + SRCH_W'(1) : '0;
    assign pick_idx   = pri_idx_flat[pick_pos*IDX_W +: IDX_W];
    assign rr_next    = IDX_W'(wrap_inc(int'(cur_q), NUM_CH));

    prisched_pick #(
        .DEPTH (PRI_DEPTH),
        .SRCH_W(SRCH_W),
        .POS_W (POS_W)
    ) u_pick (
        .vld  (pri_vld),
        .start(srch_start),
        .found(pick_found),
        .pos  (pick_pos)
    );

    prisched_demand_flag u_flag (
        .clk    (clk),
        .rst    (rst),
        .set_req(demand_set),
        .clr_req(flag_clr),
        .flag   (demand_flag)
    );

    always_comb begin
        mode_d   = mode_q;
        cur_d    = cur_q;
        res_d    = res_q;
        ptr_d    = ptr_q;
        pdone_d  = 1'b0;
        flag_clr = 1'b0;
        if (svc_done) begin
            if (mode_q == MODE_RR) begin
                if (demand_flag) begin
                    res_d = rr_next;
                    if (pick_found) begin
                        mode_d = MODE_PRI;
                        ptr_d  = pick_pos;
                        cur_d  = pick_idx;
                    end else begin
                        cur_d    = rr_next;
                        flag_clr = 1'b1;
                        pdone_d  = 1'b1;
                    end
                end else begin
                    cur_d = rr_next;
                end
            end else begin
                if (pick_found) begin
                    ptr_d = pick_pos;
                    cur_d = pick_idx;
                end else begin
                    mode_d   = MODE_RR;
                    cur_d    = res_q;
                    flag_clr = 1'b1;
                    pdone_d  = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= MODE_RR;
            cur_q   <= '0;
            res_q   <= '0;
            ptr_q   <= '0;
            pdone_q <= 1'b0;
        end else begin
            mode_q  <= mode_d;
            cur_q   <= cur_d;
            res_q   <= res_d;
            ptr_q   <= ptr_d;
            pdone_q <= pdone_d;
        end
    end

    assign serve_idx = cur_q;
    assign serve_pri = (mode_q == MODE_PRI);
    assign pass_done = pdone_q;

endmodule

// File: rtl/prio_chan_sched_chk.sv
module prio_chan_sched_chk #(
    parameter int NUM_CH    = 8,
    parameter int PRI_DEPTH = 4,
    parameter int IDX_W     = 3
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       svc_done,
    input logic                       demand_set,
    input logic [PRI_DEPTH*IDX_W-1:0] pri_idx_flat,
    input logic [PRI_DEPTH-1:0]       pri_vld,
    input logic [IDX_W-1:0]           serve_idx,
    input logic                       serve_pri,
    input logic                       demand_flag,
    input logic                       pass_done
);
    logic [IDX_W-1:0] inc_c;
    assign inc_c = (int'(serve_idx) == NUM_CH - 1) ? '0 : serve_idx + IDX_W'(1);

    a_r2_rr_advance: assert property (@(posedge clk) disable iff (rst)
        (svc_done && !serve_pri && !demand_flag) |=> (serve_idx == $past(inc_c)));

    a_r3_no_cutoff: assert property (@(posedge clk) disable iff (rst)
        !svc_done |=> ($stable(serve_idx) && $stable(serve_pri)));

    a_r3_flag_rise: assert property (@(posedge clk) disable iff (rst)
        (demand_set && !demand_flag && !svc_done) |=> demand_flag);

    a_r4_enter_pri: assert property (@(posedge clk) disable iff (rst)
        (svc_done && !serve_pri && demand_flag && (|pri_vld)) |=> serve_pri);

    a_r6_pulse_once: assert property (@(posedge clk) disable iff (rst)
        pass_done |=> !pass_done);

    a_r6_exit_state: assert property (@(posedge clk) disable iff (rst)
        pass_done |-> (!demand_flag && !serve_pri));

    a_r8_flag_covers_pass: assert property (@(posedge clk) disable iff (rst)
        serve_pri |-> demand_flag);
endmodule

bind prio_chan_sched prio_chan_sched_chk #(
    .NUM_CH   (NUM_CH),
    .PRI_DEPTH(PRI_DEPTH),
    .IDX_W    (IDX_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .svc_done    (svc_done),
    .demand_set  (demand_set),
    .pri_idx_flat(pri_idx_flat),
    .pri_vld     (pri_vld),
    .serve_idx   (serve_idx),
    .serve_pri   (serve_pri),
    .demand_flag (demand_flag),
    .pass_done   (pass_done)
);

// File: tb/prio_chan_sched_tb.sv
module prio_chan_sched_tb;
    localparam int NCH = 8;
    localparam int PD  = 4;
    localparam int IW  = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          svc_done = 1'b0;
    logic          demand_set = 1'b0;
    logic [PD*IW-1:0] pri_idx_flat = '0;
    logic [PD-1:0] pri_vld = '0;
    logic [IW-1:0] serve_idx;
    logic          serve_pri;
    logic          demand_flag;
    logic          pass_done;

    always #5 clk = ~clk;

    prio_chan_sched #(.NUM_CH(NCH), .PRI_DEPTH(PD)) u_dut (
        .clk(clk), .rst(rst), .svc_done(svc_done), .demand_set(demand_set),
        .pri_idx_flat(pri_idx_flat), .pri_vld(pri_vld),
        .serve_idx(serve_idx), .serve_pri(serve_pri),
        .demand_flag(demand_flag), .pass_done(pass_done)
    );

    typedef struct {
        int    idx;
        bit    pri;
        bit    flag;
        bit    pdone;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 0;

    // Bench model of the requirements.
    int m_cur = 0, m_res = 0, m_ptr = 0;
    bit m_pri = 0, m_flag = 0;

    task automatic check(bit ok, string req, string what, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    function automatic int find_from(int start);
        for (int k = start; k < PD; k++)
            if (pri_vld[k]) return k;
        return -1;
    endfunction

    function automatic int entry_idx(int k);
        return int'(pri_idx_flat[k*IW +: IW]);
    endfunction

    task automatic do_done(string tag);
        exp_t e;
        int   nx;
        bit   pd = 0;
        if (!m_pri) begin
            if (m_flag) begin
                m_res = (m_cur + 1) % NCH;
                nx = find_from(0);
                if (nx >= 0) begin m_pri = 1; m_ptr = nx; m_cur = entry_idx(nx); end
                else begin m_cur = m_res; m_flag = 0; pd = 1; end
            end else begin
                m_cur = (m_cur + 1) % NCH;
            end
        end else begin
            nx = find_from(m_ptr + 1);
            if (nx >= 0) begin m_ptr = nx; m_cur = entry_idx(nx); end
            else begin m_pri = 0; m_cur = m_res; m_flag = 0; pd = 1; end
        end
        e.idx = m_cur; e.pri = m_pri; e.flag = m_flag; e.pdone = pd; e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk) svc_done = 1'b1;
        @(negedge clk) svc_done = 1'b0;
    endtask

    task automatic raise_demand(string tag);
        @(negedge clk) demand_set = 1'b1;
        @(negedge clk) demand_set = 1'b0;
        m_flag = 1;
        check(demand_flag == 1'b1, tag, "demand_flag", int'(demand_flag), 1);
    endtask

    // Monitor: compares the cycle after svc_done is sampled.
    initial begin
        bit seen;
        exp_t e;
        forever begin
            @(posedge clk);
            seen = svc_done;
            @(negedge clk);
            if (seen && !rst) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "SB", "unexpected result", 0, 0);
                end else begin
                    e = exp_q.pop_front();
                    check(int'(serve_idx) == e.idx, e.tag, "serve_idx", int'(serve_idx), e.idx);
                    check(serve_pri == e.pri, e.tag, "serve_pri", int'(serve_pri), int'(e.pri));
                    check(demand_flag == e.flag, e.tag, "demand_flag", int'(demand_flag), int'(e.flag));
                    check(pass_done == e.pdone, e.tag, "pass_done", int'(pass_done), int'(e.pdone));
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int held;
        // R1 reset state
        repeat (3) @(negedge clk);
        check(serve_idx == 0, "R1", "serve_idx", int'(serve_idx), 0);
        check(serve_pri == 0, "R1", "serve_pri", int'(serve_pri), 0);
        rst = 1'b0;
        @(negedge clk);
        check(demand_flag == 0, "R1", "demand_flag", int'(demand_flag), 0);
        check(pass_done == 0, "R1", "pass_done", int'(pass_done), 0);
        check(serve_idx == 0, "R1", "serve_idx after release", int'(serve_idx), 0);

        // R2 round robin with wrap 7 -> 0
        for (int i = 0; i < 9; i++) do_done("R2");
        @(negedge clk);

        // R9 entries: e0=6 v, e1=2 v, e2=4 invalid, e3=5 v
        pri_idx_flat = {3'd5, 3'd4, 3'd2, 3'd6};
        pri_vld      = 4'b1011;

        // R3 demand raises flag, no cut-off
        held = int'(serve_idx);
        raise_demand("R3");
        repeat (3) begin
            @(negedge clk);
            check(int'(serve_idx) == held && !serve_pri, "R3", "serve_idx held", int'(serve_idx), held);
        end

        do_done("R4");         // lowest valid entry -> 6
        raise_demand("R8");    // already high: no effect on pass
        do_done("R5");         // entry 1 -> 2
        do_done("R5");         // skips entry 2 -> 5
        do_done("R6");         // resume after channel in service
        @(negedge clk);
        check(pass_done == 0, "R6", "pass_done single cycle", int'(pass_done), 0);
        check(demand_flag == 0, "R8", "flag clear after pass", int'(demand_flag), 0);
        do_done("R8");         // normal advance, pass not restarted

        // R7 no valid entry
        pri_vld = 4'b0000;
        raise_demand("R7");
        do_done("R7");
        @(negedge clk);

        // R6 resume with wrap: move to channel 7
        while (m_cur != NCH - 1) do_done("R2");
        pri_idx_flat = {3'd0, 3'd3, 3'd1, 3'd1};
        pri_vld      = 4'b0100;
        raise_demand("R3");
        do_done("R9");         // entry 2 holds 3
        do_done("R6");         // resume at 0
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "SB", "queue drained", exp_q.size(), 0);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule